// File: doc/BRIEF.md
# Link Alarm Interrupt Aggregator

This block combines many fault and warning sources into one active-low interrupt line. Receive-path faults, transmit-path faults, eight monitoring alarm flags and a link-health change indication are each masked in two levels. Per-bit masks first select which status bits count toward a path summary. A top-level enable then decides whether that summary reaches the interrupt.

Fault bits that signal a transient event latch high and clear when software reads their status register. A bit stays set if its condition is still present after the read. Level-type bits follow their inputs directly. Software reaches every status and mask register through a small select/strobe register port with combinational read data.

Top module: `lasi_aggregator`

## Requirements
- R1: `irq_n` is low exactly when some bit of the top status register (select 0) and the same bit of the top enable register (select 1) are both 1. The top enable register resets to 0, so `irq_n` is high after reset.
- R2: Link-up is the AND of `sig_detect`, `block_lock` and `lanes_aligned`. Top status bit 0 latches to 1 on every change of link-up, rising or falling, starting from a link-down reset value. A read of select 0 clears it.
- R3: Top status bit 2 is the OR of (receive status AND receive mask) gated by top enable bit 2. Top status bit 1 is built the same way from the transmit status, the transmit mask and top enable bit 1.
- R4: Transmit status bit 1 is the OR of (`mon_flags` AND transmit flag mask at select 6). Receive status bit 1 is the OR of (`mon_flags` AND receive flag mask at select 7).
- R5: The latching status bits take their condition one cycle after it appears and hold after it goes away. For receive status (select 2, input `rx_cond`) these are bits 0, 3, 4 and 5. For transmit status (select 4, input `tx_cond`) these are bits 0, 3, 4 and 6. A read of the register clears them.
- R6: A latching bit whose condition is present on the read cycle stays 1 after the read. This includes a condition that first appears on the read cycle itself.
- R7: Reset values are: receive mask (select 3) 0x0039, transmit mask (select 5) 0x0399, both flag masks 0x00, and all status bits 0.
- R8: Reserved bits read as 0 and ignore writes. Conditions on them never reach any status, alarm or `irq_n`. The writable bits are 0x023B for the receive mask, 0x03DB for the transmit mask and 0x0007 for the top enable.
- R9: Non-latching status bits follow their input in the same cycle without holding. These are receive bit 9 and transmit bits 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_cond | input | 16 | Raw receive-path fault conditions, indexed by status bit |
| tx_cond | input | 16 | Raw transmit-path fault conditions, indexed by status bit |
| mon_flags | input | 8 | Monitoring alarm flags |
| sig_detect | input | 1 | Medium signal detect |
| block_lock | input | 1 | Coding sub-layer block lock |
| lanes_aligned | input | 1 | Host-side lane alignment |
| reg_sel | input | 3 | Register select (0 top status, 1 top enable, 2 rx status, 3 rx mask, 4 tx status, 5 tx mask, 6 tx flag mask, 7 rx flag mask) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, clears latching bits of the selected status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check every cycle that an asserted condition is latched one cycle later, and that a latched bit survives any cycle without a read. They also check that any link-up change sets the link alarm, that reserved bits stay zero, and that the interrupt stays high while all top enables are zero. The bench scenarios cover the rest. These are the exact read-and-clear order (including a condition arriving on the read cycle), the reset values of the masks, the flag reductions across all bit pairs, and the interrupt under every enable combination. They also cover which written bits stick.

// File: rtl/lasi_agg_pkg.sv
package lasi_agg_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned FLAG_POS = 1;
  localparam int unsigned TOP_LS  = 0;
  localparam int unsigned TOP_TX  = 1;
  localparam int unsigned TOP_RX  = 2;
  localparam int unsigned TOP_N   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOP_STAT = 3'd0,
    SEL_TOP_EN   = 3'd1,
    SEL_RX_STAT  = 3'd2,
    SEL_RX_MASK  = 3'd3,
    SEL_TX_STAT  = 3'd4,
    SEL_TX_MASK  = 3'd5,
    SEL_TX_FMASK = 3'd6,
    SEL_RX_FMASK = 3'd7
  } reg_sel_e;

  // any bit of v selected by m
  function automatic logic masked_any(input logic [REG_W-1:0] v,
                                      input logic [REG_W-1:0] m);
    return |(v & m);
  endfunction

  // latch-high update: set wins over clear-on-read
  function automatic logic [REG_W-1:0] latch_next(input logic [REG_W-1:0] held,
                                                  input logic [REG_W-1:0] set,
                                                  input logic             clr);
    return set | (held & ~{REG_W{clr}});
  endfunction
endpackage

// File: rtl/link_watch.sv
module link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_detect,
  input  logic block_lock,
  input  logic lanes_aligned,
  input  logic clr,
  output logic link_up,
  output logic link_chg,
  output logic alarm
);
  logic link_q;
  logic alarm_q;

  assign link_up  = sig_detect & block_lock & lanes_aligned;
  assign link_chg = link_up ^ link_q;
  assign alarm    = alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      link_q  <= link_up;
      alarm_q <= link_chg | (alarm_q & ~clr);
    end
  end

  // R2
  link_change_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |=> alarm);
endmodule

// File: rtl/alarm_path.sv
module alarm_path
  import lasi_agg_pkg::*;
#(
  parameter logic [REG_W-1:0] LH_MASK  = 16'h0039,
  parameter logic [REG_W-1:0] RO_MASK  = 16'h0200,
  parameter logic [REG_W-1:0] MASK_RST = 16'h0039
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  cond,
  input  logic [FLAG_W-1:0] flags,
  input  logic              stat_rd,
  input  logic              mask_wr,
  input  logic              fmask_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  stat,
  output logic [REG_W-1:0]  mask,
  output logic [FLAG_W-1:0] fmask,
  output logic              path_hit
);
  localparam logic [REG_W-1:0] FLAG_BIT = REG_W'(1) << FLAG_POS;
  localparam logic [REG_W-1:0] IMPL     = LH_MASK | RO_MASK | FLAG_BIT;

  logic [REG_W-1:0]  lat_q;
  logic [REG_W-1:0]  mask_q;
  logic [FLAG_W-1:0] fmask_q;
  logic [REG_W-1:0]  lh_set;
  logic              flag_hit;

  assign lh_set   = cond & LH_MASK;
  assign flag_hit = |(flags & fmask_q);
  assign stat     = lat_q | (cond & RO_MASK) | (flag_hit ? FLAG_BIT : '0);
  assign mask     = mask_q;
  assign fmask    = fmask_q;
  assign path_hit = masked_any(stat, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q   <= '0;
      mask_q  <= MASK_RST & IMPL;
      fmask_q <= '0;
    end else begin
      lat_q <= latch_next(lat_q, lh_set, stat_rd);
      if (mask_wr)  mask_q  <= wdata & IMPL;
      if (fmask_wr) fmask_q <= wdata[FLAG_W-1:0];
    end
  end

  // R5
  cond_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(lh_set)) == $past(lh_set)));
  // R5
  held_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~IMPL) == '0) && ((mask_q & ~IMPL) == '0));
endmodule

// File: rtl/lasi_aggregator.sv
module lasi_aggregator
  import lasi_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] rx_cond,
  input  logic [15:0] tx_cond,
  input  logic [7:0]  mon_flags,
  input  logic        sig_detect,
  input  logic        block_lock,
  input  logic        lanes_aligned,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_n
);
  logic [TOP_N-1:0]  en_q;
  logic [REG_W-1:0]  top_stat, top_en;
  logic [REG_W-1:0]  rx_stat, rx_mask, tx_stat, tx_mask;
  logic [FLAG_W-1:0] rx_fmask, tx_fmask;
  logic              rx_hit, tx_hit, rx_alarm, tx_alarm;
  logic              ls_alarm, link_up, link_chg;
  logic              sel_top_rd, sel_rx_rd, sel_tx_rd;
  reg_sel_e          sel;

  assign sel        = reg_sel_e'(reg_sel);
  assign sel_top_rd = reg_rd && (sel == SEL_TOP_STAT);
  assign sel_rx_rd  = reg_rd && (sel == SEL_RX_STAT);
  assign sel_tx_rd  = reg_rd && (sel == SEL_TX_STAT);

  link_watch u_link (
    .clk(clk), .rst_n(rst_n),
    .sig_detect(sig_detect), .block_lock(block_lock), .lanes_aligned(lanes_aligned),
    .clr(sel_top_rd), .link_up(link_up), .link_chg(link_chg), .alarm(ls_alarm)
  );

  alarm_path #(.LH_MASK(16'h0039), .RO_MASK(16'h0200), .MASK_RST(16'h0039)) u_rx (
    .clk(clk), .rst_n(rst_n), .cond(rx_cond), .flags(mon_flags),
    .stat_rd(sel_rx_rd),
    .mask_wr(reg_wr && (sel == SEL_RX_MASK)),
    .fmask_wr(reg_wr && (sel == SEL_RX_FMASK)),
    .wdata(reg_wdata), .stat(rx_stat), .mask(rx_mask), .fmask(rx_fmask),
    .path_hit(rx_hit)
  );

  alarm_path #(.LH_MASK(16'h0059), .RO_MASK(16'h0380), .MASK_RST(16'h0399)) u_tx (
    .clk(clk), .rst_n(rst_n), .cond(tx_cond), .flags(mon_flags),
    .stat_rd(sel_tx_rd),
    .mask_wr(reg_wr && (sel == SEL_TX_MASK)),
    .fmask_wr(reg_wr && (sel == SEL_TX_FMASK)),
    .wdata(reg_wdata), .stat(tx_stat), .mask(tx_mask), .fmask(tx_fmask),
    .path_hit(tx_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                           en_q <= '0;
    else if (reg_wr && sel == SEL_TOP_EN) en_q <= reg_wdata[TOP_N-1:0];
  end

  assign rx_alarm = rx_hit & en_q[TOP_RX];
  assign tx_alarm = tx_hit & en_q[TOP_TX];

  always_comb begin
    top_stat         = '0;
    top_stat[TOP_LS] = ls_alarm;
    top_stat[TOP_TX] = tx_alarm;
    top_stat[TOP_RX] = rx_alarm;
    top_en           = {{(REG_W-TOP_N){1'b0}}, en_q};
  end

  assign irq_n = ~masked_any(top_stat, top_en);

  always_comb begin
    unique case (sel)
      SEL_TOP_STAT: reg_rdata = top_stat;
      SEL_TOP_EN:   reg_rdata = top_en;
      SEL_RX_STAT:  reg_rdata = rx_stat;
      SEL_RX_MASK:  reg_rdata = rx_mask;
      SEL_TX_STAT:  reg_rdata = tx_stat;
      SEL_TX_MASK:  reg_rdata = tx_mask;
      SEL_TX_FMASK: reg_rdata = {{(REG_W-FLAG_W){1'b0}}, tx_fmask};
      default:      reg_rdata = {{(REG_W-FLAG_W){1'b0}}, rx_fmask};
    endcase
  end

  // R1
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> irq_n);
  // R3
  rx_gated_by_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[TOP_RX] |-> !top_stat[TOP_RX]);
  // R3
  tx_gated_by_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[TOP_TX] |-> !top_stat[TOP_TX]);
  // R2
  link_follows_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (sig_detect && block_lock && lanes_aligned));
endmodule

// File: tb/lasi_aggregator_tb.sv
module lasi_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_cond = '0, tx_cond = '0;
  logic [7:0]  mon_flags = '0;
  logic        sig_detect = 1'b0, block_lock = 1'b0, lanes_aligned = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [15:0] RX_LH = 16'h0039, RX_LIVE = 16'h0200;
  localparam logic [15:0] TX_LH = 16'h0059, TX_LIVE = 16'h0380;

  always #5 clk = ~clk;

  lasi_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .rx_cond(rx_cond), .tx_cond(tx_cond),
    .mon_flags(mon_flags), .sig_detect(sig_detect), .block_lock(block_lock),
    .lanes_aligned(lanes_aligned), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with strobes low
  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic path_sweep(input bit is_tx);
    logic [15:0] v, lh, live;
    logic [2:0] s;
    lh = is_tx ? TX_LH : RX_LH;
    live = is_tx ? TX_LIVE : RX_LIVE;
    s = is_tx ? 3'd4 : 3'd2;
    for (int i = 0; i < 16; i++) begin
      if (is_tx) tx_cond = 16'(1) << i; else rx_cond = 16'(1) << i;
      @(negedge clk);
      rd(s, v);
      chk(is_tx ? "R5/R9 tx held" : "R5/R9 rx held", v, (16'(1) << i) & (lh | live));
      if (is_tx) tx_cond = '0; else rx_cond = '0;
      rd(s, v);
      chk(is_tx ? "R5/R6 tx after drop" : "R5/R6 rx after drop", v, (16'(1) << i) & lh);
      rd(s, v);
      chk(is_tx ? "R5/R8 tx cleared" : "R5/R8 rx cleared", v, 16'h0000);
    end
  endtask

  initial begin
    logic [15:0] v;
    bit prev_up, now_up;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7 reset state
    chk("R1 irq after reset", {15'd0, irq_n}, 16'h0001);
    rd(3'd1, v); chk("R1 top enable reset", v, 16'h0000);
    rd(3'd3, v); chk("R7 rx mask reset", v, 16'h0039);
    rd(3'd5, v); chk("R7 tx mask reset", v, 16'h0399);
    rd(3'd6, v); chk("R7 tx flag mask reset", v, 16'h0000);
    rd(3'd7, v); chk("R7 rx flag mask reset", v, 16'h0000);
    rd(3'd2, v); chk("R7 rx status reset", v, 16'h0000);
    rd(3'd4, v); chk("R7 tx status reset", v, 16'h0000);
    rd(3'd0, v); chk("R7 top status reset", v, 16'h0000);

    // R5 R6 R8 R9 per-bit sweeps
    path_sweep(1'b0);
    path_sweep(1'b1);

    // R6 persisting condition survives repeated reads
    rx_cond = 16'h0008;
    @(negedge clk);
    rd(3'd2, v); chk("R6 persist first read", v, 16'h0008);
    rd(3'd2, v); chk("R6 persist second read", v, 16'h0008);
    rx_cond = '0;
    rd(3'd2, v);
    rd(3'd2, v); chk("R6 cleared after removal", v, 16'h0000);

    // R6 condition arriving on the read cycle
    reg_sel = 3'd4; reg_rd = 1'b1; tx_cond = 16'h0040;
    #1 chk("R6 same-cycle read value", reg_rdata, 16'h0000);
    @(negedge clk);
    reg_rd = 1'b0; tx_cond = '0;
    rd(3'd4, v); chk("R6 same-cycle arrival kept", v, 16'h0040);

    // R4 flag reductions, every mask bit against every flag bit
    for (int j = 0; j < 8; j++) begin
      wr(3'd6, 16'(1) << j);
      wr(3'd7, 16'(1) << (7 - j));
      for (int k = 0; k < 8; k++) begin
        mon_flags = 8'(1) << k;
        #1;
        reg_sel = 3'd4;
        #1 chk("R4 tx flag", reg_rdata & 16'h0002, (j == k) ? 16'h0002 : 16'h0000);
        reg_sel = 3'd2;
        #1 chk("R4 rx flag", reg_rdata & 16'h0002, ((7 - j) == k) ? 16'h0002 : 16'h0000);
        @(negedge clk);
      end
    end
    mon_flags = '0;
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0000);

    // R8 write masks: only implemented bits stick
    wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R8 rx mask writable", v, 16'h023B);
    wr(3'd5, 16'hFFFF); rd(3'd5, v); chk("R8 tx mask writable", v, 16'h03DB);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R8 enable writable", v, 16'h0007);

    // R8 reserved conditions never reach the interrupt
    rx_cond = 16'hFC44; tx_cond = 16'hFC24;
    repeat (2) @(negedge clk);
    chk("R8 reserved no irq", {15'd0, irq_n}, 16'h0001);
    rd(3'd0, v); chk("R8 reserved no top bits", v, 16'h0000);
    rx_cond = '0; tx_cond = '0;
    wr(3'd3, 16'h0039); wr(3'd5, 16'h0399); wr(3'd1, 16'h0000);

    // R1 R3 enable sweep: rx latched bit 0, tx live bit 8, link alarm set
    sig_detect = 1; block_lock = 1; lanes_aligned = 1;
    rx_cond = 16'h0001; tx_cond = 16'h0100;
    @(negedge clk);
    rx_cond = '0;
    @(negedge clk);
    for (int e = 0; e < 8; e++) begin
      wr(3'd1, 16'(e));
      chk("R1/R3 irq vs enables", {15'd0, irq_n}, (e != 0) ? 16'h0000 : 16'h0001);
      reg_sel = 3'd0;
      #1 chk("R3 top status gated", reg_rdata & 16'h0006, 16'(e) & 16'h0006);
    end
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0004);
    chk("R3 rx masked off", {15'd0, irq_n}, 16'h0001);
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'h0002);
    chk("R3 tx masked off", {15'd0, irq_n}, 16'h0001);
    tx_cond = '0;
    wr(3'd3, 16'h0039); wr(3'd5, 16'h0399); wr(3'd1, 16'h0000);
    rd(3'd2, v);

    // R2 link change detection over all indicator combinations
    rd(3'd0, v);
    rd(3'd0, v); chk("R2 link alarm cleared", v & 16'h0001, 16'h0000);
    prev_up = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 8; c++) begin
        sig_detect = c[0]; block_lock = c[1]; lanes_aligned = c[2];
        now_up = (c == 7);
        @(negedge clk);
        @(negedge clk);
        rd(3'd0, v);
        chk("R2 link change latch", v & 16'h0001, (now_up != prev_up) ? 16'h0001 : 16'h0000);
        prev_up = now_up;
      end
    end
    wr(3'd1, 16'h0001);
    sig_detect = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 irq from link alarm", {15'd0, irq_n}, prev_up ? 16'h0000 : 16'h0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule